// File: doc/BRIEF.md
# Dual-Clock Gray-Pointer FIFO

This block carries data words from a write clock domain to an unrelated read clock domain. The two clocks may have any phase or frequency relationship. Words are stored in a dual-port register array that is used as a circular buffer. Each side keeps its own binary address counter. The counter increments in binary, and the result is re-encoded to gray code in a register. That registered gray value crosses to the other domain through a two-flop synchronizer on every bit. Each side converts the synchronized gray value back to binary to work out its flag.

Both flags are conservative by one entry, so a pointer update that arrives one cycle late can never cause an overrun or an underrun. The full flag rises one slot before the buffer is exhausted, so at most DEPTH-2 words are ever resident. The empty flag stays high while only one word is visible to the reader. That last word is released only when a further word is written behind it. Each domain has its own synchronous active-low reset.

Top module: `afifo_gray`

## Requirements
- R1: After reset, empty is 1, full is 0 and rd_data is 0.
- R2: Words are delivered on rd_data in exactly the order in which they were accepted. This holds across any number of wraps of the address counters, which wrap from the last address back to 0.
- R3: full is 1 exactly when (write counter − synchronized read counter) mod DEPTH is at least DEPTH-2. With the reader idle from reset, exactly DEPTH-2 writes are accepted.
- R4: A write attempted while full is 1 is ignored. The write counter does not move and no stored word is overwritten.
- R5: empty is 1 exactly when (synchronized write counter − read counter) mod DEPTH is at most 1. The last visible word becomes readable only after a further write has crossed.
- R6: A read attempted while empty is 1 is ignored. The read counter does not move and rd_data keeps its value.
- R7: rd_data is registered. It takes the new word on the read clock edge that accepts a read, and it holds its value on every other edge.
- R8: Each counter crosses domains as a registered gray value, and that value changes in at most one bit per clock.
- R9: After the reader frees entries, full falls once the new read counter has passed through the synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| wr_rst_n | input | 1 | Write-domain synchronous reset, active low |
| wr_en | input | 1 | Write request |
| wr_data | input | DW | Word to store |
| full | output | 1 | No further write is accepted |
| rd_clk | input | 1 | Read-domain clock |
| rd_rst_n | input | 1 | Read-domain synchronous reset, active low |
| rd_en | input | 1 | Read request |
| rd_data | output | DW | Registered output word |
| empty | output | 1 | No read is accepted |

## Verification
The hardest states to reach are the flag boundaries, where the decision rests on a counter value that is still crossing the synchronizer. The bench holds one side idle while it fills the buffer to the full threshold, or drains it to the stranded last word. It checks the flag after every single transfer and then issues requests that must be refused. A long concurrent stream then runs the two sides at unrelated rates with gapped enable patterns. This drives the counters through many wraps while the flags toggle under load.

// File: rtl/afifo_pkg.sv
// Shared helpers for the dual-clock FIFO: binary/gray conversion on a
// 32-bit container. Callers zero-extend narrower values and take a slice.
package afifo_pkg;

    // Binary to gray: each bit is XORed with the bit above it.
    function automatic logic [31:0] to_gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    // Gray to binary: bit i is the XOR of gray bits i and above.
    function automatic logic [31:0] from_gray(input logic [31:0] g);
        logic [31:0] b;
        for (int i = 0; i < 32; i++) begin
            b[i] = ^(g >> i);
        end
        return b;
    endfunction

endpackage

// File: rtl/afifo_sync.sv
// Two-stage flip-flop synchronizer, one pair per bit.
// Assumes the input comes straight from a register in the source domain.
module afifo_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    // Capture the foreign value, then let it settle for one more cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/afifo_mem.sv
// Dual-port storage: written on the write clock, read into a registered
// output on the read clock. Assumes the address logic never lets a write
// land on a slot that has not been read yet.
module afifo_mem #(
    parameter int DW = 8,
    parameter int AW = 8
) (
    input  logic          wr_clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          rd_clk,
    input  logic          rd_rst_n,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    // Store an accepted word.
    always_ff @(posedge wr_clk) begin
        if (we) cells[waddr] <= wdata;
    end

    // Register the word of an accepted read; hold otherwise.
    always_ff @(posedge rd_clk) begin
        if (!rd_rst_n)  rdata <= '0;
        else if (re)    rdata <= cells[raddr];
    end
endmodule

// File: rtl/afifo_wr_ctl.sv
// Write-side control: binary address counter, registered gray copy, and a
// full flag that asserts one entry early against the synchronized read
// counter. Assumes rd_gray_s is already synchronized to wr_clk.
module afifo_wr_ctl #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [AW-1:0] rd_gray_s,
    output logic          full,
    output logic          we,
    output logic [AW-1:0] ptr,
    output logic [AW-1:0] gray
);
    import afifo_pkg::*;

    localparam int DEPTH = 1 << AW;
    localparam logic [AW-1:0] FULL_AT = AW'(DEPTH - 2);

    logic [AW-1:0] rd_bin_s;
    logic [AW-1:0] used;
    logic [AW-1:0] ptr_nx;
    logic [31:0]   gray_nx32;

    // Decode the foreign counter and measure occupancy as seen here.
    always_comb begin
        rd_bin_s  = AW'(from_gray(32'(rd_gray_s)));
        used      = ptr - rd_bin_s;
        full      = (used >= FULL_AT);
        we        = en && !full;
        ptr_nx    = ptr + AW'(1);
        gray_nx32 = to_gray(32'(ptr_nx));
    end

    // Advance the binary counter and its registered gray image together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr  <= '0;
            gray <= '0;
        end else if (we) begin
            ptr  <= ptr_nx;
            gray <= gray_nx32[AW-1:0];
        end
    end
endmodule

// File: rtl/afifo_rd_ctl.sv
// Read-side control: binary address counter, registered gray copy, and an
// empty flag that stays high while at most one word is visible.
// Assumes wr_gray_s is already synchronized to rd_clk.
module afifo_rd_ctl #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [AW-1:0] wr_gray_s,
    output logic          empty,
    output logic          re,
    output logic [AW-1:0] ptr,
    output logic [AW-1:0] gray
);
    import afifo_pkg::*;

    logic [AW-1:0] wr_bin_s;
    logic [AW-1:0] avail;
    logic [AW-1:0] ptr_nx;
    logic [31:0]   gray_nx32;

    // Decode the foreign counter and count the words visible here.
    always_comb begin
        wr_bin_s  = AW'(from_gray(32'(wr_gray_s)));
        avail     = wr_bin_s - ptr;
        empty     = (avail <= AW'(1));
        re        = en && !empty;
        ptr_nx    = ptr + AW'(1);
        gray_nx32 = to_gray(32'(ptr_nx));
    end

    // Advance the binary counter and its registered gray image together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr  <= '0;
            gray <= '0;
        end else if (re) begin
            ptr  <= ptr_nx;
            gray <= gray_nx32[AW-1:0];
        end
    end
endmodule

// File: rtl/afifo_gray.sv
// Dual-clock FIFO top. Counters cross domains as registered gray values
// through two-flop synchronizers. Assumes the clocks are unrelated and
// each reset is held for at least two cycles of its own clock.
module afifo_gray #(
    parameter int DW = 8,
    parameter int AW = 8
) (
    input  logic          wr_clk,
    input  logic          wr_rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic          full,
    input  logic          rd_clk,
    input  logic          rd_rst_n,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic          empty
);
    logic          we, re;
    logic [AW-1:0] wr_ptr, wr_gray, rd_ptr, rd_gray;
    logic [AW-1:0] wr_gray_s, rd_gray_s;

    afifo_wr_ctl #(.AW(AW)) u_wctl (
        .clk(wr_clk), .rst_n(wr_rst_n), .en(wr_en), .rd_gray_s(rd_gray_s),
        .full(full), .we(we), .ptr(wr_ptr), .gray(wr_gray)
    );

    afifo_rd_ctl #(.AW(AW)) u_rctl (
        .clk(rd_clk), .rst_n(rd_rst_n), .en(rd_en), .wr_gray_s(wr_gray_s),
        .empty(empty), .re(re), .ptr(rd_ptr), .gray(rd_gray)
    );

    afifo_sync #(.W(AW)) u_w2r (
        .clk(rd_clk), .rst_n(rd_rst_n), .d(wr_gray), .q(wr_gray_s)
    );

    afifo_sync #(.W(AW)) u_r2w (
        .clk(wr_clk), .rst_n(wr_rst_n), .d(rd_gray), .q(rd_gray_s)
    );

    afifo_mem #(.DW(DW), .AW(AW)) u_mem (
        .wr_clk(wr_clk), .we(we), .waddr(wr_ptr), .wdata(wr_data),
        .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .re(re), .raddr(rd_ptr),
        .rdata(rd_data)
    );
endmodule

// File: rtl/afifo_gray_chk.sv
// Property checker for the dual-clock FIFO, attached to every instance
// of the top by the bind below.
module afifo_gray_chk #(
    parameter int DW = 8,
    parameter int AW = 8
) (
    input logic          wr_clk,
    input logic          wr_rst_n,
    input logic          wr_en,
    input logic          full,
    input logic [AW-1:0] wr_ptr,
    input logic [AW-1:0] wr_gray,
    input logic          rd_clk,
    input logic          rd_rst_n,
    input logic          rd_en,
    input logic          empty,
    input logic [AW-1:0] rd_ptr,
    input logic [AW-1:0] rd_gray,
    input logic [DW-1:0] rd_data
);
    // R1: the read side comes out of reset empty with a cleared output.
    a_r1_rd_reset: assert property (@(posedge rd_clk)
        !rd_rst_n |=> (empty && rd_data == '0));

    // R1: the write side comes out of reset not full.
    a_r1_wr_reset: assert property (@(posedge wr_clk)
        !wr_rst_n |=> !full);

    // R8: the crossing gray value changes in at most one bit per clock.
    a_r8_wr_gray_step: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        $countones(wr_gray ^ $past(wr_gray)) <= 1);

    a_r8_rd_gray_step: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        $countones(rd_gray ^ $past(rd_gray)) <= 1);

    // R4: a refused write leaves the write counter where it was.
    a_r4_no_overflow: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        (full && wr_en) |=> $stable(wr_ptr));

    // R6: a refused read moves neither the counter nor the output.
    a_r6_no_underflow: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (empty && rd_en) |=> ($stable(rd_ptr) && $stable(rd_data)));

    // R7: without a read request the output word holds.
    a_r7_data_hold: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        !rd_en |=> $stable(rd_data));
endmodule

bind afifo_gray afifo_gray_chk #(.DW(DW), .AW(AW)) u_chk (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en(wr_en), .full(full),
    .wr_ptr(wr_ptr), .wr_gray(wr_gray),
    .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_en(rd_en), .empty(empty),
    .rd_ptr(rd_ptr), .rd_gray(rd_gray), .rd_data(rd_data)
);

// File: tb/test_afifo_gray.sv
// Bench for the dual-clock FIFO on a small configuration (depth 8).
module test_afifo_gray;
    localparam int DW    = 8;
    localparam int AW    = 3;
    localparam int DEPTH = 1 << AW;
    localparam int CAP   = DEPTH - 2;
    localparam int NSTR  = 300;

    logic          wr_clk = 1'b0, rd_clk = 1'b0;
    logic          wr_rst_n = 1'b0, rd_rst_n = 1'b0;
    logic          wr_en = 1'b0, rd_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic          full, empty;

    int total = 0;
    int bad   = 0;
    logic [DW-1:0] q [$];

    always #5  wr_clk = ~wr_clk;   // 100 MHz write clock
    always #6.5 rd_clk = ~rd_clk;  // unrelated read clock

    afifo_gray #(.DW(DW), .AW(AW)) i_afifo_gray (
        .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .full(full), .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_en(rd_en),
        .rd_data(rd_data), .empty(empty)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Watchdog: counts as a failed check and still reports.
    initial begin
        #1500000;
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int nacc, nrd;
        logic acc;
        logic [DW-1:0] prev, expv;

        // Reset both domains.
        repeat (4) @(negedge rd_clk);
        @(negedge wr_clk) wr_rst_n = 1'b1;
        @(negedge rd_clk) rd_rst_n = 1'b1;
        check("R1 empty", 32'(empty), 1);
        check("R1 full", 32'(full), 0);
        check("R1 rd_data", 32'(rd_data), 0);

        // Fill with the reader idle; flag must track accepted count.
        nacc = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge wr_clk);
            check("R3 full level", 32'(full), 32'(nacc >= CAP));
            acc     = !full;
            wr_en   = 1'b1;
            wr_data = DW'(8'h10 + i);
            if (acc) begin
                q.push_back(wr_data);
                nacc++;
            end
        end
        @(negedge wr_clk) wr_en = 1'b0;
        check("R3 accepted writes", 32'(nacc), 32'(CAP));

        // Let the write counter cross, then drain with one-cycle reads.
        repeat (6) @(negedge rd_clk);
        nrd  = 0;
        prev = rd_data;
        for (int k = 0; k < 8; k++) begin
            @(negedge rd_clk);
            check("R5 empty level", 32'(empty), 32'((CAP - nrd) <= 1));
            acc   = !empty;
            rd_en = 1'b1;
            @(negedge rd_clk);
            rd_en = 1'b0;
            if (acc) begin
                expv = q.pop_front();
                check("R2/R4/R7 read word", 32'(rd_data), 32'(expv));
                nrd++;
            end else begin
                check("R6 data held on refused read", 32'(rd_data), 32'(prev));
            end
            prev = rd_data;
        end
        check("R5 reads before stranding", 32'(nrd), 32'(CAP - 1));

        // Freed entries must release full once the read counter crosses.
        repeat (6) @(negedge wr_clk);
        check("R9 full released", 32'(full), 0);

        // One more write releases the stranded word.
        @(negedge wr_clk);
        wr_en = 1'b1; wr_data = 8'hA0; q.push_back(8'hA0);
        @(negedge wr_clk) wr_en = 1'b0;
        repeat (6) @(negedge rd_clk);
        check("R5 stranded word visible", 32'(empty), 0);
        @(negedge rd_clk) rd_en = 1'b1;
        @(negedge rd_clk) rd_en = 1'b0;
        expv = q.pop_front();
        check("R5 stranded word value", 32'(rd_data), 32'(expv));
        check("R5 empty again", 32'(empty), 1);

        // Concurrent stream through many wraps at gapped, unrelated rates.
        fork
            begin : writer
                int nwr = 0;
                int cyc = 0;
                while (nwr < NSTR) begin
                    @(negedge wr_clk);
                    cyc++;
                    wr_en   = (cyc % 4 != 2);
                    wr_data = DW'(nwr * 37 + 5);
                    if (wr_en && !full) begin
                        q.push_back(wr_data);
                        nwr++;
                    end
                end
                @(negedge wr_clk) wr_en = 1'b0;
            end
            begin : reader
                int got = 0;
                int cyc = 0;
                logic pend = 1'b0;
                logic [DW-1:0] ev = '0;
                while (got < NSTR && cyc < 20000) begin
                    @(negedge rd_clk);
                    cyc++;
                    if (pend) begin
                        check("R2/R8 stream order", 32'(rd_data), 32'(ev));
                        pend = 1'b0;
                        got++;
                    end
                    rd_en = (cyc % 3 != 1);
                    if (rd_en && !empty) begin
                        if (q.size() == 0) begin
                            check("R5 read with nothing written", 1, 0);
                        end else begin
                            ev   = q.pop_front();
                            pend = 1'b1;
                        end
                    end
                end
                @(negedge rd_clk);
                rd_en = 1'b0;
                if (pend) begin
                    check("R2/R8 stream order", 32'(rd_data), 32'(ev));
                    got++;
                end
                check("R2 stream count", 32'(got), 32'(NSTR));
            end
        join
        repeat (8) @(negedge rd_clk);
        check("R5 one word left resident", 32'(q.size()), 1);
        check("R5 empty with one resident", 32'(empty), 1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule